// File: doc/BRIEF.md
# Operand Addressing-Mode and Constant-Generator Decoder

This block takes one 16-bit instruction word and sorts out how its operands are addressed. It works out the instruction format from the top bits. For two-operand and one-operand words it reports the source mode and register, the destination mode and register, and the byte/word flag. It also reports how many extension words follow the instruction in the code stream and how far the source register moves after an auto-increment access. When the source register field, together with the source mode bits, selects a hard-wired constant, the block flags this and supplies the 16-bit constant value. The block does no memory access and no execution.

Words enter on a valid/ready stream, and the decoded record leaves on a second valid/ready stream one cycle later. A word transfers on any rising edge where `in_valid` and `in_ready` are both high, and the same rule applies to the output. The one-entry output register frees up, and `in_ready` goes high, when the register is empty or is being drained in that cycle. A full stage can therefore accept a word in every cycle. While `out_valid` is high and `out_ready` is low, every output holds still.

Top module: `amd_operand_decoder`

## Requirements
- R1: The format (`out_fmt`) comes from word bits [15:12]. The value 0001 gives single=1. The values 0010 and 0011 give jump=2. Values of 0100 and above give double=3. The value 0000 gives none=0. For jump and none, the source mode is register (0), the destination mode is none (4), and the registers, byte flag, constant, extension count and increment are all zero.
- R2: The source mode bits sit at [5:4]. For any register other than 0, 2 and 3, the codes map as follows: 00 gives register (0), 01 gives indexed (1), 10 gives indirect (2), and 11 gives auto-increment (3).
- R3: For register 0, code 01 gives symbolic (4) and code 11 gives immediate (6). Codes 00 and 10 keep the modes register and indirect.
- R4: For register 2, code 00 gives register (0) and code 01 gives absolute (5). Code 10 gives a constant (mode 7) of 4, and code 11 gives a constant of 8.
- R5: Register 3 always gives a constant (mode 7). The value is 0, 1, 2 or FFFFh for codes 00, 01, 10 and 11. `out_const_vld` is high exactly when the source mode is constant.
- R6: In a double-operand word, the destination mode bit is [7] and the destination register is [3:0]. A 0 gives register (0). A 1 gives symbolic (2) for register 0, absolute (3) for register 2, and indexed (1) for any other register.
- R7: `out_ext_words` counts one word for an indexed, symbolic, absolute or immediate source, plus one word for a destination whose mode bit is 1. A constant source counts none.
- R8: `out_incr` is 1 for a byte auto-increment source and 2 for a word auto-increment source. In every other case it is 0, including immediate and constant sources.
- R9: `out_byte` is bit [6]. `out_src_reg` is [11:8] for double and [3:0] for single. `out_dst_reg` is [3:0] for double and 0 otherwise.
- R10: The decode for an accepted word appears one cycle later. Outputs hold while stalled. After reset, `out_valid` is 0 and `in_ready` is 1.
- R11: A single-operand word decodes its [5:4]/[3:0] operand as the source. Its destination mode is none (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Stage can take a word |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_fmt | output | 2 | Format code |
| out_src_mode | output | 3 | Source mode code |
| out_src_reg | output | 4 | Source register number |
| out_dst_mode | output | 3 | Destination mode code |
| out_dst_reg | output | 4 | Destination register number |
| out_byte | output | 1 | Byte operation |
| out_const_vld | output | 1 | Source replaced by constant |
| out_const | output | 16 | Constant value |
| out_ext_words | output | 2 | Extension words following |
| out_incr | output | 2 | Source auto-increment step |

## Verification
The hardest cases to reach are the special register/mode pairs. These are the constants on registers 2 and 3, the symbolic, absolute and immediate forms, and the two-word destinations that combine with them. Uniformly random words rarely produce them. The stimulus therefore starts with directed words for each special encoding. It then biases the random register fields toward 0, 2 and 3. A second hard case is a stalled record being held while a new word waits. Random `out_ready` creates back-to-back stalls, and the bench checks that the held record does not change between stall cycles.

// File: rtl/amd_pkg.sv
package amd_pkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 4;

  typedef enum logic [2:0] {
    SM_REG   = 3'd0,
    SM_IDX   = 3'd1,
    SM_IND   = 3'd2,
    SM_AINC  = 3'd3,
    SM_SYM   = 3'd4,
    SM_ABS   = 3'd5,
    SM_IMM   = 3'd6,
    SM_CONST = 3'd7
  } src_mode_e;

  typedef enum logic [2:0] {
    DM_REG  = 3'd0,
    DM_IDX  = 3'd1,
    DM_SYM  = 3'd2,
    DM_ABS  = 3'd3,
    DM_NONE = 3'd4
  } dst_mode_e;

  typedef enum logic [1:0] {
    FMT_NONE   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_JUMP   = 2'd2,
    FMT_DOUBLE = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e              fmt;
    src_mode_e         smode;
    logic [REG_W-1:0]  sreg;
    dst_mode_e         dmode;
    logic [REG_W-1:0]  dreg;
    logic              byte_op;
    logic              cvld;
    logic [WORD_W-1:0] cval;
    logic [1:0]        ext;
    logic [1:0]        incr;
  } dec_t;
endpackage

// File: rtl/amd_src_decode.sv
module amd_src_decode
  import amd_pkg::*;
#(
  parameter int               RW        = 4,
  parameter int               WW        = 16,
  parameter logic [RW-1:0]    PC_IDX    = '0,
  parameter logic [RW-1:0]    SR_IDX    = RW'(2),
  parameter logic [RW-1:0]    CG_IDX    = RW'(3),
  parameter logic [1:0]       BYTE_STEP = 2'd1,
  parameter logic [1:0]       WORD_STEP = 2'd2
) (
  input  logic [RW-1:0] reg_i,
  input  logic [1:0]    as_i,
  input  logic          byte_i,
  output src_mode_e     mode_o,
  output logic          cvld_o,
  output logic [WW-1:0] cval_o,
  output logic [1:0]    incr_o,
  output logic          ext_o
);
  always_comb begin
    mode_o = src_mode_e'({1'b0, as_i});
    cvld_o = 1'b0;
    cval_o = '0;
    if (reg_i == CG_IDX) begin
      cvld_o = 1'b1;
      mode_o = SM_CONST;
      unique case (as_i)
        2'b00:   cval_o = '0;
        2'b01:   cval_o = WW'(1);
        2'b10:   cval_o = WW'(2);
        default: cval_o = '1;
      endcase
    end else if (reg_i == SR_IDX) begin
      unique case (as_i)
        2'b01: mode_o = SM_ABS;
        2'b10: begin mode_o = SM_CONST; cvld_o = 1'b1; cval_o = WW'(4); end
        2'b11: begin mode_o = SM_CONST; cvld_o = 1'b1; cval_o = WW'(8); end
        default: mode_o = SM_REG;
      endcase
    end else if (reg_i == PC_IDX) begin
      if (as_i == 2'b01) mode_o = SM_SYM;
      else if (as_i == 2'b11) mode_o = SM_IMM;
    end
  end

  always_comb begin
    incr_o = '0;
    if (mode_o == SM_AINC) incr_o = byte_i ? BYTE_STEP : WORD_STEP;
  end

  assign ext_o = (mode_o == SM_IDX) || (mode_o == SM_SYM) ||
                 (mode_o == SM_ABS) || (mode_o == SM_IMM);
endmodule

// File: rtl/amd_dst_decode.sv
module amd_dst_decode
  import amd_pkg::*;
#(
  parameter int            RW     = 4,
  parameter logic [RW-1:0] PC_IDX = '0,
  parameter logic [RW-1:0] SR_IDX = RW'(2)
) (
  input  logic          en_i,
  input  logic          ad_i,
  input  logic [RW-1:0] reg_i,
  output dst_mode_e     mode_o,
  output logic          ext_o
);
  always_comb begin
    if (!en_i)                 mode_o = DM_NONE;
    else if (!ad_i)            mode_o = DM_REG;
    else if (reg_i == PC_IDX)  mode_o = DM_SYM;
    else if (reg_i == SR_IDX)  mode_o = DM_ABS;
    else                       mode_o = DM_IDX;
  end

  assign ext_o = en_i & ad_i;
endmodule

// File: rtl/amd_operand_decoder.sv
module amd_operand_decoder
  import amd_pkg::*;
#(
  parameter logic [REG_W-1:0] PC_IDX = '0,
  parameter logic [REG_W-1:0] SR_IDX = REG_W'(2),
  parameter logic [REG_W-1:0] CG_IDX = REG_W'(3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_fmt,
  output logic [2:0]        out_src_mode,
  output logic [REG_W-1:0]  out_src_reg,
  output logic [2:0]        out_dst_mode,
  output logic [REG_W-1:0]  out_dst_reg,
  output logic              out_byte,
  output logic              out_const_vld,
  output logic [WORD_W-1:0] out_const,
  output logic [1:0]        out_ext_words,
  output logic [1:0]        out_incr
);
  localparam int OP_HI = WORD_W - 1;
  localparam int OP_LO = WORD_W - 4;

  fmt_e              fmt_w;
  logic              has_ops, is_double;
  logic [REG_W-1:0]  sreg_w;
  src_mode_e         smode_w;
  dst_mode_e         dmode_w;
  logic              scvld_w, sext_w, dext_w;
  logic [WORD_W-1:0] scval_w;
  logic [1:0]        sincr_w;
  dec_t              dec_d, dec_q;
  logic              take;

  always_comb begin
    if (in_word[OP_HI:OP_LO] == 4'b0001)      fmt_w = FMT_SINGLE;
    else if (in_word[OP_HI:OP_LO+1] == 3'b001) fmt_w = FMT_JUMP;
    else if (in_word[OP_HI:OP_LO+2] != 2'b00)  fmt_w = FMT_DOUBLE;
    else                                       fmt_w = FMT_NONE;
  end

  assign is_double = (fmt_w == FMT_DOUBLE);
  assign has_ops   = is_double || (fmt_w == FMT_SINGLE);
  assign sreg_w    = is_double ? in_word[11:8] : in_word[3:0];

  amd_src_decode #(
    .RW(REG_W), .WW(WORD_W), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX), .CG_IDX(CG_IDX)
  ) u_src (
    .reg_i(sreg_w), .as_i(in_word[5:4]), .byte_i(in_word[6]),
    .mode_o(smode_w), .cvld_o(scvld_w), .cval_o(scval_w),
    .incr_o(sincr_w), .ext_o(sext_w)
  );

  amd_dst_decode #(
    .RW(REG_W), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX)
  ) u_dst (
    .en_i(is_double), .ad_i(in_word[7]), .reg_i(in_word[3:0]),
    .mode_o(dmode_w), .ext_o(dext_w)
  );

  always_comb begin
    dec_d       = '0;
    dec_d.fmt   = fmt_w;
    dec_d.smode = SM_REG;
    dec_d.dmode = DM_NONE;
    if (has_ops) begin
      dec_d.smode   = smode_w;
      dec_d.sreg    = sreg_w;
      dec_d.dmode   = dmode_w;
      dec_d.dreg    = is_double ? in_word[3:0] : '0;
      dec_d.byte_op = in_word[6];
      dec_d.cvld    = scvld_w;
      dec_d.cval    = scval_w;
      dec_d.ext     = {1'b0, sext_w} + {1'b0, dext_w};
      dec_d.incr    = sincr_w;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dec_q     <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        dec_q     <= dec_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(dec_q));
  a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  a_r5_const_no_incr: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_const_vld |-> out_incr == 2'd0 && out_src_mode == SM_CONST);
  a_r7_ext_limit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ext_words != 2'd3);
  a_r8_incr_only_ainc: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_incr != 2'd0 |-> out_src_mode == SM_AINC);
  a_r11_no_dst_unless_double: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt != FMT_DOUBLE |-> out_dst_mode == DM_NONE);

  assign out_fmt       = dec_q.fmt;
  assign out_src_mode  = dec_q.smode;
  assign out_src_reg   = dec_q.sreg;
  assign out_dst_mode  = dec_q.dmode;
  assign out_dst_reg   = dec_q.dreg;
  assign out_byte      = dec_q.byte_op;
  assign out_const_vld = dec_q.cvld;
  assign out_const     = dec_q.cval;
  assign out_ext_words = dec_q.ext;
  assign out_incr      = dec_q.incr;
endmodule

// File: tb/amd_operand_decoder_test.sv
module amd_operand_decoder_test;
  import amd_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_word = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [1:0] out_fmt;
  logic [2:0] out_src_mode, out_dst_mode;
  logic [3:0] out_src_reg, out_dst_reg;
  logic out_byte, out_const_vld;
  logic [15:0] out_const;
  logic [1:0] out_ext_words, out_incr;

  int n_cmp = 0;
  int n_bad = 0;
  dec_t exp_q[$];
  bit   held = 0;
  logic [40:0] held_val;

  always #10 clk = ~clk;

  amd_operand_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_fmt(out_fmt), .out_src_mode(out_src_mode), .out_src_reg(out_src_reg),
    .out_dst_mode(out_dst_mode), .out_dst_reg(out_dst_reg), .out_byte(out_byte),
    .out_const_vld(out_const_vld), .out_const(out_const),
    .out_ext_words(out_ext_words), .out_incr(out_incr)
  );

  function automatic dec_t ref_dec(logic [15:0] w);
    dec_t r;
    logic [3:0] sr;
    logic [1:0] as;
    logic dbl;
    r = '0;
    r.dmode = DM_NONE;
    r.smode = SM_REG;
    if (w[15:12] == 4'h1) r.fmt = FMT_SINGLE;
    else if (w[15:13] == 3'b001) r.fmt = FMT_JUMP;
    else if (w[15:14] != 2'b00) r.fmt = FMT_DOUBLE;
    else r.fmt = FMT_NONE;
    if (r.fmt == FMT_JUMP || r.fmt == FMT_NONE) return r;
    dbl = (r.fmt == FMT_DOUBLE);
    sr = dbl ? w[11:8] : w[3:0];
    as = w[5:4];
    r.sreg = sr;
    r.byte_op = w[6];
    if (sr == 4'd3) begin
      r.smode = SM_CONST; r.cvld = 1'b1;
      r.cval = (as == 2'd0) ? 16'h0 : (as == 2'd1) ? 16'h1 : (as == 2'd2) ? 16'h2 : 16'hFFFF;
    end else if (sr == 4'd2 && as[1]) begin
      r.smode = SM_CONST; r.cvld = 1'b1;
      r.cval = as[0] ? 16'h8 : 16'h4;
    end else if (sr == 4'd2 && as == 2'd1) r.smode = SM_ABS;
    else if (sr == 4'd0 && as == 2'd1) r.smode = SM_SYM;
    else if (sr == 4'd0 && as == 2'd3) r.smode = SM_IMM;
    else r.smode = src_mode_e'({1'b0, as});
    r.incr = (r.smode == SM_AINC) ? (w[6] ? 2'd1 : 2'd2) : 2'd0;
    r.ext = 2'((r.smode == SM_IDX || r.smode == SM_SYM || r.smode == SM_ABS ||
                r.smode == SM_IMM) ? 1 : 0) + 2'((dbl && w[7]) ? 1 : 0);
    if (dbl) begin
      r.dreg = w[3:0];
      if (!w[7]) r.dmode = DM_REG;
      else if (w[3:0] == 4'd0) r.dmode = DM_SYM;
      else if (w[3:0] == 4'd2) r.dmode = DM_ABS;
      else r.dmode = DM_IDX;
    end
    return r;
  endfunction

  task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, fld, act, exp);
    end
  endtask

  function automatic logic [40:0] snap();
    return {out_fmt, out_src_mode, out_src_reg, out_dst_mode, out_dst_reg, out_byte,
            out_const_vld, out_const, out_ext_words, out_incr};
  endfunction

  task automatic compare(dec_t e);
    string stag, ctag, dtag;
    stag = (e.sreg == 4'd0) ? "R3" : (e.sreg == 4'd2) ? "R4" : (e.sreg == 4'd3) ? "R5" : "R2";
    ctag = (e.sreg == 4'd2) ? "R4" : "R5";
    dtag = (e.fmt == FMT_SINGLE) ? "R11" : "R6";
    chk("R1", "fmt", 32'(out_fmt), 32'(e.fmt));
    chk(stag, "src_mode", 32'(out_src_mode), 32'(e.smode));
    chk("R9", "src_reg", 32'(out_src_reg), 32'(e.sreg));
    chk(dtag, "dst_mode", 32'(out_dst_mode), 32'(e.dmode));
    chk("R9", "dst_reg", 32'(out_dst_reg), 32'(e.dreg));
    chk("R9", "byte", 32'(out_byte), 32'(e.byte_op));
    chk(ctag, "const_vld", 32'(out_const_vld), 32'(e.cvld));
    chk(ctag, "const", 32'(out_const), 32'(e.cval));
    chk("R7", "ext_words", 32'(out_ext_words), 32'(e.ext));
    chk("R8", "incr", 32'(out_incr), 32'(e.incr));
  endtask

  // Called once per cycle, after inputs for the coming edge are settled.
  task automatic eval(output bit accepted);
    dec_t e;
    if (held) begin
      chk("R10", "valid_held", 32'(out_valid), 32'd1);
      chk("R10", "data_held", 32'(snap()), 32'(held_val));
      chk("R10", "data_held_hi", 32'(snap() >> 32), 32'(held_val >> 32));
    end
    held = 0;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk("R10", "spurious_valid", 32'd1, 32'd0);
      else begin
        e = exp_q.pop_front();
        compare(e);
      end
    end else if (out_valid) begin
      held = 1;
      held_val = snap();
    end
    accepted = in_valid && in_ready;
    if (accepted) exp_q.push_back(ref_dec(in_word));
  endtask

  task automatic send(logic [15:0] w);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1;
    in_word = w;
    out_ready = ($urandom % 4) != 0;
    #1 eval(acc);
    while (!acc) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      #1 eval(acc);
    end
  endtask

  task automatic idle();
    bit acc;
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    #1 eval(acc);
  endtask

  function automatic logic [3:0] pick_reg(logic [3:0] r);
    case ($urandom % 5)
      0: return 4'd0;
      1: return 4'd2;
      2: return 4'd3;
      default: return r;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'h5EED_0430));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    chk("R10", "reset_out_valid", 32'(out_valid), 32'd0);
    chk("R10", "reset_in_ready", 32'(in_ready), 32'd1);

    // Directed corner cases
    send(16'h4504); // R2 register to register
    send(16'h45D4); // R2 R6 indexed to indexed, byte
    send(16'h45B4); // R8 auto-increment word, indexed dst
    send(16'h45F4); // R8 auto-increment byte
    send(16'h4035); // R3 immediate
    send(16'h4090); // R3 R6 symbolic to symbolic, two words
    send(16'h4292); // R4 R6 absolute to absolute, two words
    send(16'h4222); // R4 constant 4
    send(16'h42B2); // R4 constant 8, absolute dst
    send(16'h4305); // R5 constant 0
    send(16'h5315); // R5 constant 1
    send(16'h8325); // R5 constant 2
    send(16'h4335); // R5 constant FFFF, no increment
    send(16'h4303); // R5 no-op form
    send(16'h1005); // R11 single register
    send(16'h1010); // R11 single symbolic
    send(16'h1032); // R11 single constant 8
    send(16'h2FE4); // R1 jump
    send(16'h3FE3); // R1 jump
    send(16'h0ABC); // R1 none
    for (int i = 0; i < 3000; i++) begin
      w = 16'($urandom);
      w[11:8] = pick_reg(w[11:8]);
      w[3:0]  = pick_reg(w[3:0]);
      send(w);
    end
    repeat (4) idle();
    chk("R10", "drained", 32'(exp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule